// File: doc/BRIEF.md
# Status-Register Hardware Semaphore

This block holds a single lock bit that several processors use to take turns on a shared bus controller. The lock lives in one bit of a status register reached through a simple register bus. Reading that register is an atomic test-and-set: the read returns the lock state as it was before the access, and if the lock was free the same access takes it. A processor that reads the bit as 0 owns the controller. A processor that reads it as 1 must retry later; any retry limit is left to software.

Release is write-one-to-clear on the same bit. A write with the lock bit at 0 has no effect, so a write can touch the register without freeing someone else's lock. Each read strobe is counted once, on the cycle it is first seen high, so a strobe held for several cycles cannot take the lock twice or report a misleading second value. Read data is registered and comes with a one-cycle valid pulse.

Top module: `status_semaphore`

## Requirements
- R1: After reset the lock is free: `lock_held` is 0, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: A read accepted at the status offset (default 0x8) while the lock is free returns `rd_data` with bit 0 = 0, and `lock_held` is 1 from the next cycle on.
- R3: A read accepted at the status offset while the lock is held returns `rd_data` bit 0 = 1 and leaves `lock_held` at 1.
- R4: A write at the status offset with `wr_data` bit 0 = 1 releases the lock: `lock_held` is 0 in the next cycle when no read is accepted in the same cycle.
- R5: A write at the status offset with `wr_data` bit 0 = 0 leaves the lock unchanged, whatever the other data bits hold.
- R6: Reads and writes at any other offset leave the lock unchanged, and such reads return all zeros.
- R7: A read is accepted only on the cycle `rd_en` is first sampled high; holding `rd_en` high takes the lock at most once and `rd_valid` pulses for exactly one cycle per strobe.
- R8: When a release write and a status read are accepted in the same cycle, the read returns bit 0 = 0 and the lock is held afterwards.
- R9: `rd_data` bits other than bit 0 are always 0, and `rd_data` is valid in the cycle after the read is accepted, marked by `rd_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe; accepted on its first high cycle |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data; bit 0 = 1 releases the lock |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a new result |
| lock_held | output | 1 | Current lock state |

## Verification
Every effect of an accepted access lands exactly one clock edge after it: the bench drives the strobes on a falling edge, lets one rising edge pass, then samples `rd_data`, `rd_valid` and `lock_held` on the next falling edge. Between two accesses it inserts one idle cycle with `rd_en` low so that each read is a fresh strobe. The held-strobe case samples again on the falling edges after the first result to confirm the valid pulse has ended and the lock did not move. A bench model tracks the expected lock across a seeded random mix of reads, writes, paired release-and-read cycles and off-target offsets.

// File: rtl/status_semaphore_pkg.sv
package status_semaphore_pkg;
   // Access decoded for one cycle, shared by the decode and the lock core.
   typedef struct packed {
      logic rd_hit;   // accepted read of the status offset
      logic rd_miss;  // accepted read of another offset
      logic rel_hit;  // write to status offset with lock bit set
   } sem_access_t;
endpackage

// File: rtl/sem_access_decode.sv
module sem_access_decode
   import status_semaphore_pkg::*;
#(
   parameter int               ADDR_W     = 4,
   parameter int               DATA_W     = 8,
   parameter int               LOCK_BIT   = 0,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output sem_access_t       acc
);
   logic rd_seen_q;
   logic rd_accept;
   logic at_status;

   always_ff @(posedge clk) begin
      if (!rst_n) rd_seen_q <= 1'b0;
      else        rd_seen_q <= rd_en;
   end

   assign rd_accept   = rd_en && !rd_seen_q;
   assign at_status   = (addr == STATUS_OFS);

   always_comb begin
      acc.rd_hit  = rd_accept && at_status;
      acc.rd_miss = rd_accept && !at_status;
      acc.rel_hit = wr_en && at_status && wr_data[LOCK_BIT];
   end

   // R7: a strobe held high is never accepted twice in a row
   a_r7_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd_hit || acc.rd_miss) |=> !(acc.rd_hit || acc.rd_miss));
endmodule

// File: rtl/sem_lock_core.sv
module sem_lock_core
   import status_semaphore_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  sem_access_t acc,
   output logic        seen_free,  // lock value the current read observes
   output logic        lock_q
);
   // A same-cycle release is applied first, so the read observes a free lock.
   assign seen_free = !lock_q || acc.rel_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)          lock_q <= 1'b0;
      else if (acc.rd_hit) lock_q <= 1'b1;
      else if (acc.rel_hit) lock_q <= 1'b0;
   end

   a_r2_free_read_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd_hit && !lock_q) |=> lock_q);
   a_r3_held_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd_hit && lock_q) |=> lock_q);
   a_r4_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rel_hit && !acc.rd_hit) |=> !lock_q);
   a_r5_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc.rel_hit && !acc.rd_hit) |=> $stable(lock_q));
   a_r8_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rel_hit && acc.rd_hit) |=> lock_q);
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port
   import status_semaphore_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LOCK_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sem_access_t       acc,
   input  logic              seen_free,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic [DATA_W-1:0] word_d;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == LOCK_BIT) begin : g_lock
            assign word_d[b] = acc.rd_hit && !seen_free;
         end else begin : g_zero
            assign word_d[b] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= acc.rd_hit || acc.rd_miss;
         if (acc.rd_hit || acc.rd_miss) rd_data <= word_d;
      end
   end

   a_r9_pad_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($countones(rd_data) <= 1));
   a_r6_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      acc.rd_miss |=> (rd_data == '0));
endmodule

// File: rtl/status_semaphore.sv
module status_semaphore
   import status_semaphore_pkg::*;
#(
   parameter int               ADDR_W     = 4,
   parameter int               DATA_W     = 8,
   parameter int               LOCK_BIT   = 0,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              lock_held
);
   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (LOCK_BIT >= 0 && LOCK_BIT < DATA_W) else $error("LOCK_BIT outside word");
      assert (ADDR_W >= 1) else $error("ADDR_W must be positive");
   end

   sem_access_t acc;
   logic        seen_free;

   sem_access_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT), .STATUS_OFS(STATUS_OFS)
   ) i_decode (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
      .wr_en(wr_en), .wr_data(wr_data), .acc(acc)
   );

   sem_lock_core i_core (
      .clk(clk), .rst_n(rst_n), .acc(acc), .seen_free(seen_free), .lock_q(lock_held)
   );

   sem_read_port #(.DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT)) i_rport (
      .clk(clk), .rst_n(rst_n), .acc(acc), .seen_free(seen_free),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // R7: valid is a single-cycle pulse while the strobe stays high
   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_en) |=> !rd_valid);
endmodule

// File: tb/test_status_semaphore.sv
module test_status_semaphore;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam logic [ADDR_W-1:0] OFS = 4'h8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic rd_en = 1'b0, wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic rd_valid, lock_held;

   int n_cmp = 0, n_bad = 0;
   logic exp_lock = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   status_semaphore i_status_semaphore (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .lock_held(lock_held)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] exp_word(input bit rd, input bit hit,
                                                  input bit rel, input logic lk);
      if (rd && hit) return {{(DATA_W-1){1'b0}}, lk && !rel};
      return '0;
   endfunction

   function automatic logic next_lock(input bit rd, input bit hit, input bit rel, input logic lk);
      if (rd && hit) return 1'b1;
      if (rel) return 1'b0;
      return lk;
   endfunction

   // One access: drive at a falling edge, check at the next, then one idle cycle.
   task automatic access(input string req, input bit rd, input bit wr,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      bit hit, rel;
      logic [DATA_W-1:0] ew;
      hit = (a == OFS);
      rel = wr && hit && d[0];
      ew  = exp_word(rd, hit, rel, exp_lock);
      addr = a; rd_en = rd; wr_en = wr; wr_data = d;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      exp_lock = next_lock(rd, hit, rel, exp_lock);
      check({req, " valid"}, rd_valid, rd);
      if (rd) check({req, " data"}, rd_data, ew);
      check({req, " lock"}, lock_held, exp_lock);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 lock", lock_held, 0);
      check("R1 valid", rd_valid, 0);
      check("R1 data", rd_data, 0);

      access("R2 free read", 1, 0, OFS, 8'h00);
      access("R3 held read", 1, 0, OFS, 8'h00);
      access("R5 zero write", 0, 1, OFS, 8'hFE);
      access("R6 other write", 0, 1, 4'h3, 8'hFF);
      access("R6 other read", 1, 0, 4'h9, 8'h00);
      access("R4 release", 0, 1, OFS, 8'h01);
      access("R6 other read free", 1, 0, 4'h0, 8'h00);
      access("R2 retake", 1, 0, OFS, 8'h00);
      access("R8 release+read", 1, 1, OFS, 8'h01);
      access("R4 release again", 0, 1, OFS, 8'hFF);

      // R7: hold the strobe for four cycles
      addr = OFS; rd_en = 1'b1;
      @(negedge clk);
      check("R7 first valid", rd_valid, 1);
      check("R7 first data", rd_data, 0);
      exp_lock = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R7 held no valid", rd_valid, 0);
         check("R7 held lock", lock_held, 1);
      end
      rd_en = 1'b0;
      @(negedge clk);

      for (int i = 0; i < 500; i++) begin
         int unsigned r;
         logic [ADDR_W-1:0] a;
         r = $urandom_range(0, 3);
         a = ($urandom_range(0, 3) == 0) ? ADDR_W'($urandom) : OFS;
         case (r)
            0: access("R2/R3 rand read", 1, 0, a, 8'h00);
            1: access("R4/R5 rand write", 0, 1, a, DATA_W'($urandom));
            2: access("R8 rand both", 1, 1, a, DATA_W'($urandom));
            default: access("R6 rand idle", 0, 0, a, 8'h00);
         endcase
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule